// File: doc/BRIEF.md
# Centroid Sample Position Selector

This block picks the sub-pixel point at which a pixel's attributes are interpolated when the pixel is rendered with four samples per pixel. It takes the pixel's 4-bit sample coverage, the interpolation mode, a centroid request flag and a multisampling-enable bit. It returns a fixed-point x/y offset from the pixel's top-left corner, plus a flag that tells whether the pixel centre was chosen.

The centroid is not averaged from the covered samples. The block applies two rules instead. When every sample is covered, the point is the pixel centre. When only some samples are covered, the point is the covered sample with the lowest index. Either way the returned point lies inside the primitive whenever at least one sample is covered.

The selection is combinational. A parameter can add one output register stage.

Top module: `centroid_pos_sel`

## Requirements
- R1: Sample positions are, in 1/16-pixel units from the top-left corner (x,y): index 0 at (6,2), index 1 at (14,6), index 2 at (2,10), index 3 at (10,14). The centre is at (8,8). Coverage bit k of `cov_mask` belongs to sample index k. For FRAC_W above 4, every coordinate is shifted left by FRAC_W-4.
- R2: When all four coverage bits are set, the output is the centre and `at_centre` is 1.
- R3: Centroid selection is active when `msaa_en` is 1, `centroid_en` is 1 and the mode is not constant. While it is active and the coverage is partial but non-zero, the output is the position of the lowest-index covered sample and `at_centre` is 0.
- R4: When `msaa_en` is 0, the output is the centre with `at_centre` 1, whatever the other inputs are.
- R5: `interp_mode` encoding: 0 is constant, 1 is perspective, 2 is no-perspective, and 3 behaves as no-perspective. In constant mode the centroid flag is ignored and the output is the centre with `at_centre` 1.
- R6: When `centroid_en` is 0, the output is the centre with `at_centre` 1.
- R7: A zero coverage mask, as for a helper pixel, gives the centre with `at_centre` 1.
- R8: With OUT_REG=0 the outputs follow the inputs in the same cycle. With OUT_REG=1 they appear one clock later, and while reset is held they show the centre with `at_centre` 1.
- R9: Whenever `at_centre` is 0, the returned position is that of a sample whose coverage bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the output register stage |
| rst_n | input | 1 | Active-low synchronous reset of the output register stage |
| cov_mask | input | 4 | Sample coverage, bit k for sample index k |
| interp_mode | input | 2 | 0 constant, 1 perspective, 2 no-perspective, 3 treated as no-perspective |
| centroid_en | input | 1 | Centroid interpolation requested |
| msaa_en | input | 1 | Multisampling enabled |
| pos_x | output | FRAC_W | Horizontal offset from the pixel's left edge |
| pos_y | output | FRAC_W | Vertical offset from the pixel's top edge |
| at_centre | output | 1 | The pixel centre was selected |

## Verification
The bench sweeps every combination of the 16 coverage masks, the four modes, the centroid flag and the enable bit. Single-bit masks check each sample coordinate on its own. Multi-bit partial masks such as 0110, 1100 and 1010 separate the lowest-index rule from any other pick. The full mask and the zero mask show the two cases that fall back to the centre even though centroid selection is active. The all-disabled, constant-mode and flag-low cases show that each gating input overrides on its own. A second instance with the register stage runs the same sweep, so its one-cycle latency and its reset value are checked against the same expected values.

// File: rtl/centroid_pos_sel.sv
module centroid_pos_sel #(
  parameter int FRAC_W  = 4,
  parameter bit OUT_REG = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cov_mask,
  input  logic [1:0]        interp_mode,
  input  logic              centroid_en,
  input  logic              msaa_en,
  output logic [FRAC_W-1:0] pos_x,
  output logic [FRAC_W-1:0] pos_y,
  output logic              at_centre
);

  localparam int SH = FRAC_W - 4;
  localparam logic [FRAC_W-1:0] CTR = FRAC_W'(8) << SH;
  localparam logic [FRAC_W-1:0] X0 = FRAC_W'(6)  << SH;
  localparam logic [FRAC_W-1:0] Y0 = FRAC_W'(2)  << SH;
  localparam logic [FRAC_W-1:0] X1 = FRAC_W'(14) << SH;
  localparam logic [FRAC_W-1:0] Y1 = FRAC_W'(6)  << SH;
  localparam logic [FRAC_W-1:0] X2 = FRAC_W'(2)  << SH;
  localparam logic [FRAC_W-1:0] Y2 = FRAC_W'(10) << SH;
  localparam logic [FRAC_W-1:0] X3 = FRAC_W'(10) << SH;
  localparam logic [FRAC_W-1:0] Y3 = FRAC_W'(14) << SH;

  logic              partial, use_sample;
  logic [FRAC_W-1:0] sel_x, sel_y;
  logic              sel_ctr;

  assign partial    = (cov_mask != 4'h0) && (cov_mask != 4'hF);
  assign use_sample = msaa_en && centroid_en && (interp_mode != 2'd0) && partial;

  always_comb begin
    sel_x   = CTR;
    sel_y   = CTR;
    sel_ctr = 1'b1;
    if (use_sample) begin
      sel_ctr = 1'b0;
      if (cov_mask[0]) begin
        sel_x = X0; sel_y = Y0;
      end else if (cov_mask[1]) begin
        sel_x = X1; sel_y = Y1;
      end else if (cov_mask[2]) begin
        sel_x = X2; sel_y = Y2;
      end else begin
        sel_x = X3; sel_y = Y3;
      end
    end
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pos_x     <= CTR;
          pos_y     <= CTR;
          at_centre <= 1'b1;
        end else begin
          pos_x     <= sel_x;
          pos_y     <= sel_y;
          at_centre <= sel_ctr;
        end
      end
    end else begin : g_comb
      assign pos_x     = sel_x;
      assign pos_y     = sel_y;
      assign at_centre = sel_ctr;
    end
  endgenerate

endmodule

// File: rtl/centroid_pos_sel_chk.sv
module centroid_pos_sel_chk #(
  parameter int FRAC_W  = 4,
  parameter bit OUT_REG = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        cov_mask,
  input logic [1:0]        interp_mode,
  input logic              centroid_en,
  input logic              msaa_en,
  input logic [FRAC_W-1:0] pos_x,
  input logic [FRAC_W-1:0] pos_y,
  input logic              at_centre
);

  localparam int SH = FRAC_W - 4;
  localparam logic [FRAC_W-1:0] CTR = FRAC_W'(8) << SH;

  logic [3:0] cov_q;
  logic [1:0] mode_q;
  logic       cen_q, ms_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cov_q <= 4'h0; mode_q <= 2'd0; cen_q <= 1'b0; ms_q <= 1'b0;
    end else begin
      cov_q <= cov_mask; mode_q <= interp_mode; cen_q <= centroid_en; ms_q <= msaa_en;
    end
  end

  logic [3:0] cov_d;
  logic [1:0] mode_d;
  logic       cen_d, ms_d;
  assign cov_d  = OUT_REG ? cov_q  : cov_mask;
  assign mode_d = OUT_REG ? mode_q : interp_mode;
  assign cen_d  = OUT_REG ? cen_q  : centroid_en;
  assign ms_d   = OUT_REG ? ms_q   : msaa_en;

  logic hit0, hit1, hit2, hit3;
  assign hit0 = (pos_x == (FRAC_W'(6)  << SH)) && (pos_y == (FRAC_W'(2)  << SH));
  assign hit1 = (pos_x == (FRAC_W'(14) << SH)) && (pos_y == (FRAC_W'(6)  << SH));
  assign hit2 = (pos_x == (FRAC_W'(2)  << SH)) && (pos_y == (FRAC_W'(10) << SH));
  assign hit3 = (pos_x == (FRAC_W'(10) << SH)) && (pos_y == (FRAC_W'(14) << SH));

  assert_full_cov_centre_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cov_d == 4'hF) |-> at_centre);

  assert_lowest_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_d && cen_d && mode_d != 2'd0 && cov_d != 4'h0 && cov_d != 4'hF) |->
      (!at_centre && (cov_d[0] ? hit0 : cov_d[1] ? hit1 : cov_d[2] ? hit2 : hit3)));

  assert_msaa_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_d |-> at_centre);

  assert_constant_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_d == 2'd0) |-> at_centre);

  assert_flag_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cen_d |-> at_centre);

  assert_zero_cov_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cov_d == 4'h0) |-> at_centre);

  assert_centre_coords_R1: assert property (@(posedge clk) disable iff (!rst_n)
    at_centre |-> (pos_x == CTR && pos_y == CTR));

  assert_inside_prim_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !at_centre |-> ((hit0 && cov_d[0]) || (hit1 && cov_d[1]) ||
                    (hit2 && cov_d[2]) || (hit3 && cov_d[3])));

endmodule

bind centroid_pos_sel centroid_pos_sel_chk #(.FRAC_W(FRAC_W), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/test_centroid_pos_sel.sv
module test_centroid_pos_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cov_mask = 4'h0;
  logic [1:0] interp_mode = 2'd0;
  logic       centroid_en = 1'b0;
  logic       msaa_en = 1'b0;
  logic [3:0] cx, cy, rx, ry;
  logic       cc, rc;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  centroid_pos_sel #(.FRAC_W(4), .OUT_REG(1'b0)) i_centroid_pos_sel (
    .clk, .rst_n, .cov_mask, .interp_mode, .centroid_en, .msaa_en,
    .pos_x(cx), .pos_y(cy), .at_centre(cc));

  centroid_pos_sel #(.FRAC_W(4), .OUT_REG(1'b1)) i_centroid_pos_sel_q (
    .clk, .rst_n, .cov_mask, .interp_mode, .centroid_en, .msaa_en,
    .pos_x(rx), .pos_y(ry), .at_centre(rc));

  task automatic check(input string req, input logic [3:0] ax, ay, input logic ac,
                       input logic [3:0] ex, ey, input logic ec);
    checks++;
    if (ax !== ex || ay !== ey || ac !== ec) begin
      errors++;
      $display("FAIL %s actual (%0d,%0d,c=%0b) expected (%0d,%0d,c=%0b) mask=%b mode=%0d cen=%0b ms=%0b",
               req, ax, ay, ac, ex, ey, ec, cov_mask, interp_mode, centroid_en, msaa_en);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int sx[4] = '{6, 14, 2, 10};
    int sy[4] = '{2, 6, 10, 14};
    // R8: reset value of the registered stage is the centre, even with active partial coverage
    @(negedge clk);
    cov_mask = 4'b0100; interp_mode = 2'd1; centroid_en = 1'b1; msaa_en = 1'b1;
    @(posedge clk); #2;
    check("R8 reset", rx, ry, rc, 4'd8, 4'd8, 1'b1);
    @(posedge clk); #2;
    check("R8 reset hold", rx, ry, rc, 4'd8, 4'd8, 1'b1);
    @(negedge clk); rst_n = 1'b1;

    for (int ms = 0; ms < 2; ms++)
      for (int ce = 0; ce < 2; ce++)
        for (int md = 0; md < 4; md++)
          for (int m = 0; m < 16; m++) begin
            logic [3:0] ex, ey;
            logic       ec;
            string      req;
            int         k;
            @(negedge clk);
            cov_mask = 4'(m); interp_mode = 2'(md); centroid_en = ce[0]; msaa_en = ms[0];
            ex = 4'd8; ey = 4'd8; ec = 1'b1;
            if (ms == 0)                  req = "R4";
            else if (md == 0)             req = "R5";
            else if (ce == 0)             req = "R6";
            else if (m == 0)              req = "R7";
            else if (m == 15)             req = "R2";
            else begin
              k = 0;
              while (((m >> k) & 1) == 0) k++;
              ex = 4'(sx[k]); ey = 4'(sy[k]); ec = 1'b0;
              req = ($countones(4'(m)) == 1) ? "R1" : "R3";
            end
            @(posedge clk); #2;
            check(req, cx, cy, cc, ex, ey, ec);
            check("R8 registered", rx, ry, rc, ex, ey, ec);
            if (!cc) begin
              checks++;
              if (!((cx == 4'(sx[0]) && cy == 4'(sy[0]) && cov_mask[0]) ||
                    (cx == 4'(sx[1]) && cy == 4'(sy[1]) && cov_mask[1]) ||
                    (cx == 4'(sx[2]) && cy == 4'(sy[2]) && cov_mask[2]) ||
                    (cx == 4'(sx[3]) && cy == 4'(sy[3]) && cov_mask[3]))) begin
                errors++;
                $display("FAIL R9 actual (%0d,%0d) expected a covered sample of mask %b", cx, cy, cov_mask);
              end
            end
          end

    // R8: the registered output lags one clock behind the combinational one
    @(negedge clk);
    cov_mask = 4'b1000; interp_mode = 2'd2; centroid_en = 1'b1; msaa_en = 1'b1;
    @(posedge clk); #2;
    @(negedge clk);
    cov_mask = 4'b1111;
    #1;
    check("R8 comb same cycle", cx, cy, cc, 4'd8, 4'd8, 1'b1);
    check("R8 registered lag", rx, ry, rc, 4'd10, 4'd14, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule